// File: doc/BRIEF.md
# Tag-Only Cache Controller with Next-Line Prefetch

This block models one level of set-associative cache for traffic accounting. It keeps only tags, valid bits and replacement order; no data is stored. Each request carries a 48-bit byte address and a read/write flag and is accepted with a valid/ready handshake. One cycle after acceptance, a done pulse reports whether the demand access hit. Four free-running 32-bit counters hold memory reads, memory writes, demand hits and demand misses. Fed with an address stream, they give the miss ratio and the memory traffic of a given geometry and policy.

Set count, way count and block size are power-of-two parameters. One set gives a fully associative cache, and one way gives a direct-mapped cache. Two runtime inputs set the behaviour. One selects first-in-first-out or least-recently-used replacement. The other enables a next-line prefetcher. On a demand miss, the prefetcher also looks up the block that follows the missed block. For that lookup, `req_ready_o` drops for one cycle.

The cache is write-through and allocates on a write miss. A write miss costs one block read followed by one memory write.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset all four counters are zero, `req_ready_o` is 1, `done_o` is 0 and every line is invalid, so the first access to any block misses.
- R2: A request accepted on a clock edge (`req_valid_i` and `req_ready_o` both 1) gives `done_o`=1 for exactly the following cycle. In that cycle `done_hit_o` holds the demand result, and exactly one of the hit and miss counters has gone up by one.
- R3: Every accepted write (`req_write_i`=1) adds one to the memory-write counter, whether it hits or misses. Reads never change that counter.
- R4: A write miss adds one memory read and allocates the block, so a following access to the same block hits.
- R5: A demand read miss adds one memory read and allocates the block. A demand hit adds no memory read.
- R6: With `repl_lru_i`=0 (FIFO), a full set evicts the way that was filled earliest, and demand hits leave that order unchanged.
- R7: With `repl_lru_i`=1 (LRU), a full set evicts the least recently used way, and every demand hit makes its way the most recent.
- R8: With `pf_en_i`=1, a demand miss on block number B (address divided by the block size) also looks up block B+1. If B+1 is absent, it is allocated like a missed block and adds one memory read.
- R9: If the next block is already resident, the prefetch adds no memory read and leaves the replacement order of its set unchanged, under either policy.
- R10: Prefetch lookups never change the hit or miss counters, and a demand hit never starts a prefetch.
- R11: While a prefetch lookup is in progress, `req_ready_o` is 0 for exactly one cycle. The demand access is resolved and allocated before the prefetch lookup.
- R12: Invalid ways are filled before any valid way is evicted, so a set holds as many distinct blocks as it has ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 48 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| pf_en_i | input | 1 | Enable next-line prefetch on a demand miss |
| repl_lru_i | input | 1 | 1 = LRU replacement, 0 = FIFO replacement |
| done_o | output | 1 | One-cycle pulse after acceptance |
| done_hit_o | output | 1 | Demand result, valid with done_o |
| mem_rd_cnt_o | output | 32 | Block reads from memory |
| mem_wr_cnt_o | output | 32 | Writes to memory |
| hit_cnt_o | output | 32 | Demand hits |
| miss_cnt_o | output | 32 | Demand misses |

## Verification
A corrupted tag, valid bit or age shows up as a wrong `done_hit_o` on a later access to the affected set, and as a read counter that is off by one from then on. A wrong victim choice shows up when the evicted block is next touched, which may be several accesses later. For this reason the stimulus reuses a small pool of blocks over few sets. A reference model keeps an ordered block list for each set and compares the hit result and all four counters after every request. Directed sequences pin the eviction order under each policy and the silent prefetch hit. In these sequences a wrong choice appears within three accesses.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PF   = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 44,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit_o) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages_i,
  output logic [WAY_W-1:0]            way_o
);
  logic found;

  // lowest invalid way first, else the oldest way
  always_comb begin
    found = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        found = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages_i[w] == WAY_W'(WAYS - 1)) way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_age_update.sv
module cache_age_update #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][WAY_W-1:0]  ages_i,
  input  logic [WAY_W-1:0]            way_i,
  output logic [WAYS-1:0][WAY_W-1:0]  ages_o
);
  logic [WAY_W-1:0] ref_age;
  assign ref_age = ages_i[way_i];

  // touched way becomes youngest; younger ones age by one
  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (WAY_W'(w) == way_i)      ages_o[w] = '0;
      else if (ages_i[w] < ref_age) ages_o[w] = ages_i[w] + WAY_W'(1);
      else                          ages_o[w] = ages_i[w];
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 2,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              pf_en_i,
  input  logic              repl_lru_i,
  output logic              done_o,
  output logic              done_hit_o,
  output logic [CNT_W-1:0]  mem_rd_cnt_o,
  output logic [CNT_W-1:0]  mem_wr_cnt_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int SET_LG = $clog2(NUM_SETS);
  localparam int SET_W  = (SET_LG > 0) ? SET_LG : 1;
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - SET_LG;

  ctl_state_e st_q;
  logic [BLK_W-1:0] pf_blk_q;

  logic [NUM_WAYS-1:0]             valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0][TAG_W-1:0]  tag_q   [NUM_SETS];
  logic [NUM_WAYS-1:0][WAY_W-1:0]  age_q   [NUM_SETS];

  logic [BLK_W-1:0] sel_blk;
  logic [SET_W-1:0] sel_set;
  logic [TAG_W-1:0] sel_tag;

  logic                            hit;
  logic [WAY_W-1:0]                hit_way, vic_way, tgt_way;
  logic [NUM_WAYS-1:0][WAY_W-1:0]  ages_new;
  logic accept, pf_step, alloc, touch;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign pf_step     = (st_q == ST_PF);

  assign sel_blk = pf_step ? pf_blk_q : req_addr_i[ADDR_W-1:OFF_W];
  assign sel_tag = sel_blk[BLK_W-1:SET_LG];

  if (SET_LG > 0) begin : g_idx
    assign sel_set = sel_blk[SET_W-1:0];
  end else begin : g_noidx
    assign sel_set = '0;
  end

  cache_tag_lookup #(.WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .valid_i (valid_q[sel_set]),
    .tags_i  (tag_q[sel_set]),
    .tag_i   (sel_tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  cache_victim_pick #(.WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i (valid_q[sel_set]),
    .ages_i  (age_q[sel_set]),
    .way_o   (vic_way)
  );

  assign tgt_way = hit ? hit_way : vic_way;

  cache_age_update #(.WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_age (
    .ages_i (age_q[sel_set]),
    .way_i  (tgt_way),
    .ages_o (ages_new)
  );

  // fill on any miss; a hit only reorders for a demand access under LRU
  assign alloc = (accept || pf_step) && !hit;
  assign touch = alloc || (accept && hit && repl_lru_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        for (int w = 0; w < NUM_WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (touch) age_q[sel_set] <= ages_new;
      if (alloc) begin
        valid_q[sel_set][tgt_way] <= 1'b1;
        tag_q[sel_set][tgt_way]   <= sel_tag;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pf_blk_q <= '0;
    end else if (pf_step) begin
      st_q <= ST_IDLE;
    end else if (accept && !hit && pf_en_i) begin
      st_q     <= ST_PF;
      pf_blk_q <= sel_blk + BLK_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      done_hit_o   <= 1'b0;
      mem_rd_cnt_o <= '0;
      mem_wr_cnt_o <= '0;
      hit_cnt_o    <= '0;
      miss_cnt_o   <= '0;
    end else begin
      done_o <= accept;
      if (accept) done_hit_o <= hit;
      if (alloc) mem_rd_cnt_o <= mem_rd_cnt_o + CNT_W'(1);
      if (accept && req_write_i) mem_wr_cnt_o <= mem_wr_cnt_o + CNT_W'(1);
      if (accept && hit) hit_cnt_o <= hit_cnt_o + CNT_W'(1);
      if (accept && !hit) miss_cnt_o <= miss_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_write_i,
  input logic             done_o,
  input logic             done_hit_o,
  input logic [CNT_W-1:0] mem_rd_cnt_o,
  input logic [CNT_W-1:0] mem_wr_cnt_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o
);
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> done_o); // R2

  AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i && req_ready_o)); // R2

  AST_HIT_CNT_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (done_o && done_hit_o)); // R2

  AST_MISS_CNT_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (done_o && !done_hit_o)); // R2

  AST_WR_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_cnt_o != $past(mem_wr_cnt_o)) |-> $past(req_valid_i && req_ready_o && req_write_i)); // R3

  AST_NO_READ_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_hit_o) |-> (mem_rd_cnt_o == $past(mem_rd_cnt_o))); // R5

  AST_PF_NO_HITMISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o))); // R10

  AST_PF_HIT_NO_PF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_hit_o) |-> req_ready_o); // R10

  AST_PF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o); // R11
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .done_o       (done_o),
  .done_hit_o   (done_hit_o),
  .mem_rd_cnt_o (mem_rd_cnt_o),
  .mem_wr_cnt_o (mem_wr_cnt_o),
  .hit_cnt_o    (hit_cnt_o),
  .miss_cnt_o   (miss_cnt_o)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;
  localparam int NS   = 4;
  localparam int NW   = 2;
  localparam int BLK  = 4;
  localparam int OFFB = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [47:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        pf_en_i = 1'b0;
  logic        repl_lru_i = 1'b0;
  logic        done_o, done_hit_o;
  logic [31:0] mem_rd_cnt_o, mem_wr_cnt_o, hit_cnt_o, miss_cnt_o;

  always #5 clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(48), .NUM_SETS(NS), .NUM_WAYS(NW),
                   .BLOCK_BYTES(BLK), .CNT_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .pf_en_i(pf_en_i),
    .repl_lru_i(repl_lru_i), .done_o(done_o), .done_hit_o(done_hit_o),
    .mem_rd_cnt_o(mem_rd_cnt_o), .mem_wr_cnt_o(mem_wr_cnt_o),
    .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  int checks = 0;
  int errors = 0;

  // reference: per set, blocks ordered newest/most-recent first
  logic [45:0] m_blk [NS][NW];
  int          m_n [NS];
  int unsigned e_rd, e_wr, e_hit, e_miss;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) m_n[s] = 0;
    e_rd = 0; e_wr = 0; e_hit = 0; e_miss = 0;
  endtask

  task automatic model_touch(input logic [45:0] blk, input bit demand,
                             input bit lru, output bit hit);
    int s;
    int pos;
    s   = int'(blk % NS);
    pos = -1;
    for (int i = 0; i < m_n[s]; i++) if (m_blk[s][i] == blk) pos = i;
    hit = (pos >= 0);
    if (hit) begin
      if (demand && lru) begin
        for (int i = pos; i > 0; i--) m_blk[s][i] = m_blk[s][i-1];
        m_blk[s][0] = blk;
      end
    end else begin
      if (m_n[s] < NW) m_n[s]++;
      for (int i = m_n[s] - 1; i > 0; i--) m_blk[s][i] = m_blk[s][i-1];
      m_blk[s][0] = blk;
    end
  endtask

  task automatic check_counters(input string req);
    chk(mem_rd_cnt_o == e_rd,   req, "mem_rd_cnt", mem_rd_cnt_o, e_rd);
    chk(mem_wr_cnt_o == e_wr,   req, "mem_wr_cnt", mem_wr_cnt_o, e_wr);
    chk(hit_cnt_o    == e_hit,  req, "hit_cnt",    hit_cnt_o,    e_hit);
    chk(miss_cnt_o   == e_miss, req, "miss_cnt",   miss_cnt_o,   e_miss);
  endtask

  // called at a negedge with ready high; exp_hit < 0 means no directed value
  task automatic do_access(input logic [47:0] addr, input bit wr, input bit pf,
                           input bit lru, input int exp_hit, input string req);
    bit mh, ph, pf_go;
    logic [45:0] blk;
    blk = addr[47:OFFB];
    model_touch(blk, 1'b1, lru, mh);
    if (mh) e_hit++; else begin e_miss++; e_rd++; end
    if (wr) e_wr++;
    pf_go = pf && !mh;
    if (pf_go) begin
      model_touch(blk + 46'd1, 1'b0, lru, ph);
      if (!ph) e_rd++;
    end
    req_addr_i  = addr;
    req_write_i = wr;
    pf_en_i     = pf;
    repl_lru_i  = lru;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(done_o == 1'b1, "R2", "done_o", done_o, 1);
    chk(done_hit_o == mh, req, "done_hit_o vs model", done_hit_o, mh);
    if (exp_hit >= 0) chk(done_hit_o == exp_hit[0], req, "done_hit_o directed", done_hit_o, exp_hit);
    chk(req_ready_o == !pf_go, "R11", "req_ready_o", req_ready_o, !pf_go);
    if (pf_go) begin
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R2", "done_o after prefetch", done_o, 0);
      chk(req_ready_o == 1'b1, "R11", "ready back", req_ready_o, 1);
    end
    check_counters(req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready after reset", req_ready_o, 1);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check_counters("R1");
  endtask

  function automatic logic [47:0] ba(input int b);
    return 48'(b) << OFFB;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(negedge clk);
    apply_reset();

    // R1: cold miss
    do_access(ba(1) | 48'd3, 1'b0, 1'b0, 1'b0, 0, "R1");
    // R3, R4: write miss reads then writes; follow-up hits
    do_access(ba(5), 1'b1, 1'b0, 1'b0, 0, "R4");
    do_access(ba(5) | 48'd2, 1'b0, 1'b0, 1'b0, 1, "R4");
    do_access(ba(5), 1'b1, 1'b0, 1'b0, 1, "R3");
    // R12: set 3 takes two blocks before evicting
    do_access(ba(3), 1'b0, 1'b0, 1'b0, 0, "R12");
    do_access(ba(7), 1'b0, 1'b0, 1'b0, 0, "R12");
    do_access(ba(3), 1'b0, 1'b0, 1'b0, 1, "R12");
    do_access(ba(7), 1'b0, 1'b0, 1'b0, 1, "R12");
    // R6: FIFO in set 0
    do_access(ba(0), 1'b0, 1'b0, 1'b0, 0, "R6");
    do_access(ba(4), 1'b0, 1'b0, 1'b0, 0, "R6");
    do_access(ba(0), 1'b0, 1'b0, 1'b0, 1, "R6");
    do_access(ba(8), 1'b0, 1'b0, 1'b0, 0, "R6");
    do_access(ba(4), 1'b0, 1'b0, 1'b0, 1, "R6");
    do_access(ba(0), 1'b0, 1'b0, 1'b0, 0, "R6");
    // R7: LRU in set 2
    do_access(ba(2), 1'b0, 1'b0, 1'b1, 0, "R7");
    do_access(ba(6), 1'b0, 1'b0, 1'b1, 0, "R7");
    do_access(ba(2), 1'b0, 1'b0, 1'b1, 1, "R7");
    do_access(ba(10), 1'b0, 1'b0, 1'b1, 0, "R7");
    do_access(ba(2), 1'b0, 1'b0, 1'b1, 1, "R7");
    do_access(ba(6), 1'b0, 1'b0, 1'b1, 0, "R7");

    // R8, R11: prefetch of absent next block
    apply_reset();
    do_access(ba(12), 1'b0, 1'b1, 1'b0, 0, "R8");
    chk(mem_rd_cnt_o == 32'd2, "R8", "reads after miss+prefetch", mem_rd_cnt_o, 2);
    do_access(ba(13), 1'b0, 1'b0, 1'b0, 1, "R8");
    // R10: hit with prefetch enabled does not prefetch
    do_access(ba(13), 1'b1, 1'b1, 1'b0, 1, "R10");
    do_access(ba(14), 1'b0, 1'b0, 1'b0, 0, "R10");

    // R9: resident prefetch target keeps LRU order
    apply_reset();
    do_access(ba(5), 1'b0, 1'b0, 1'b1, 0, "R9");
    do_access(ba(1), 1'b0, 1'b0, 1'b1, 0, "R9");
    do_access(ba(4), 1'b0, 1'b1, 1'b1, 0, "R9");
    chk(mem_rd_cnt_o == 32'd3, "R9", "no read for resident prefetch", mem_rd_cnt_o, 3);
    do_access(ba(9), 1'b0, 1'b0, 1'b1, 0, "R9");
    do_access(ba(1), 1'b0, 1'b0, 1'b1, 1, "R9");
    do_access(ba(5), 1'b0, 1'b0, 1'b1, 0, "R9");

    // mixed random traffic against the model
    apply_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [47:0] a;
      int b;
      b = int'($urandom_range(0, 23));
      a = ba(b) | 48'($urandom_range(0, BLK - 1));
      if ($urandom_range(0, 7) == 0) a[44] = 1'b1;
      do_access(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), -1, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule